// File: doc/BRIEF.md
# Cascaded Display-Driver Serial Loader

This block pushes one display frame into a chain of one or two serial-in display-driver shift registers and then latches it. Each driver stage is `DRV_BITS` wide (20 by default), so a chain holds 20 or 40 bits. The frame arrives as a packed byte array, with byte `k` on `frame_i[8k+7:8k]`. A chain of two drivers fills the array exactly. A single driver uses only the low 20 bits, so the first bit sent sits inside the top used byte and not at a byte boundary.

A request is a one-cycle `start_i` while `busy_o` is low. On that edge the frame and the chain-length select `dual_i` are captured. The block then drives the data line, toggles the shift clock once per bit, waits one low phase, and pulses the load line. The phase lengths come from the system clock period parameter, so the driver's timing minimums hold at any system clock: at least 90 ns clock high, at least 200 ns clock period, and at least 55 ns load high.

The sequencer uses six named states:
- ST_IDLE: waiting for a request.
- ST_SETUP: data valid, clock low.
- ST_HIGH: clock high.
- ST_GAP: low phase after the last bit.
- ST_LOAD: load high.
- ST_FIN: the done cycle.

Its transitions are:
- ST_IDLE/ST_FIN → ST_SETUP on an accepted start.
- ST_SETUP → ST_HIGH when the phase timer expires.
- ST_HIGH → ST_SETUP (advance to the next bit) or → ST_GAP (last bit sent).
- ST_GAP → ST_LOAD.
- ST_LOAD → ST_FIN.
- ST_FIN → ST_IDLE when no start is present.

Top module: `vfd_chain_loader`

## Requirements
- R1: While reset is asserted, and on release, `vfd_din_o`, `vfd_clk_o`, `vfd_load_o`, `busy_o` and `done_o` are all 0.
- R2: `start_i` is accepted only on an edge where `busy_o` is 0. `busy_o` is 1 from the cycle after that edge. A `start_i`, `frame_i` or `dual_i` change while busy leaves the serial stream unchanged.
- R3: With `dual_i`=0, exactly 20 bits are sent. They go in the order `frame_i[19]` down to `frame_i[0]`: byte 2 bit 3 first, then bytes 1 and 0 most-significant bit first. Bits 7..4 of byte 2 and all higher bytes are never sent.
- R4: With `dual_i`=1, exactly 40 bits are sent, from `frame_i[39]` (byte 4 bit 7) down to `frame_i[0]`.
- R5: Each data bit is placed on `vfd_din_o` when its low phase starts, LO cycles before the rising clock edge. It stays stable while `vfd_clk_o` is high.
- R6: With T the system clock period:
  - Each shift clock is high for HI = ceil(90 ns / T) cycles.
  - Each shift clock is low for LO = max(1, ceil(200 ns / T) − HI) cycles.
  - At 4 ns these are HI=23 and LO=27.
- R7: After the last clock falls, the line stays low for LO cycles. `vfd_load_o` is then high for LD = max(1, ceil(55 ns / T)) cycles; LD=14 at 4 ns. `vfd_load_o` is never high together with `vfd_clk_o`.
- R8: `done_o` is high for exactly one cycle, starting on the edge where `vfd_load_o` falls, and `busy_o` falls on that same edge. Measured from the accepting edge, that edge comes N·(HI+LO)+LO+LD cycles later, where N is the bit count.
- R9: While not busy, `vfd_clk_o` and `vfd_load_o` are low, and `vfd_din_o` holds the last bit sent (0 after reset).
- R10: A start present during the `done_o` cycle is accepted on the next edge, so a new frame begins back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send the presented frame |
| dual_i | input | 1 | 1 selects a two-driver chain (40 bits), 0 a single driver (20 bits) |
| frame_i | input | 40 | Frame bytes, byte k at bits 8k+7:8k |
| vfd_din_o | output | 1 | Serial data to the first driver |
| vfd_clk_o | output | 1 | Shift clock, sampled by the driver on its rising edge |
| vfd_load_o | output | 1 | Latch-load strobe, active high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result of this block is a fixed offset from the accepting edge, counted in system cycles:
- Bit k is placed on the data line at k·(HI+LO).
- The clock of bit k rises LO cycles later.
- The load line rises at N·(HI+LO)+LO.
- Done and the busy drop come LD cycles after the load rise.

The bench keeps a cycle counter from each accepting edge and derives every expected pin level from these offsets. It compares all five outputs on the falling edge of every cycle, so any single-cycle slip in any phase is seen. Ignored starts and back-to-back requests are checked through that same continuous comparison of the serial stream.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    // Driver timing minimums in picoseconds
    localparam int SCLK_HIGH_MIN_PS   = 90000;
    localparam int SCLK_PERIOD_MIN_PS = 200000;
    localparam int LOAD_HIGH_MIN_PS   = 55000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_GAP,
        ST_LOAD,
        ST_FIN
    } ldr_state_t;

    function automatic int div_up(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vfd_phase_timer.sv
module vfd_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/vfd_frame_shifter.sv
module vfd_frame_shifter #(
    parameter int DRV_BITS = 20,
    parameter int FRAME_W  = 40,
    parameter int IN_W     = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic            advance_i,
    input  logic            dual_i,
    input  logic [IN_W-1:0] frame_i,
    output logic            data_o,
    output logic            last_o
);

    localparam int LEFT_W  = $clog2(FRAME_W);
    localparam int SHORT_W = FRAME_W - DRV_BITS;

    logic [FRAME_W-1:0] sh_q;
    logic [LEFT_W-1:0]  left_q;
    logic [FRAME_W-1:0] single_aligned;
    logic [FRAME_W-1:0] dual_aligned;

    // Left-align the selected frame so the first bit to send sits at the top
    assign single_aligned = {frame_i[DRV_BITS-1:0], {SHORT_W{1'b0}}};
    assign dual_aligned   = frame_i[FRAME_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (capture_i) begin
            sh_q   <= dual_i ? dual_aligned : single_aligned;
            left_q <= dual_i ? LEFT_W'(FRAME_W - 1) : LEFT_W'(DRV_BITS - 1);
        end else if (advance_i) begin
            sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign data_o = sh_q[FRAME_W-1];
    assign last_o = (left_q == '0);

    AST_NO_ADVANCE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n) advance_i |-> !last_o); // R3
    AST_CAPTURE_EXCL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) !(capture_i && advance_i)); // R2

endmodule

// File: rtl/vfd_seq_fsm.sv
module vfd_seq_fsm
    import vfd_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int HI_CYC = 23,
    parameter int LO_CYC = 27,
    parameter int LD_CYC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tmr_zero_i,
    input  logic             last_bit_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             capture_o,
    output logic             advance_o,
    output logic             sclk_o,
    output logic             load_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] HI_RELOAD = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_RELOAD = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RELOAD = CNT_W'(LD_CYC - 1);
    localparam int RUN_W = CNT_W + 1;

    ldr_state_t state_q, state_n;
    logic sclk_q, load_q, busy_q, done_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_n    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        capture_o  = 1'b0;
        advance_o  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (start_i) begin
                    state_n    = ST_SETUP;
                    capture_o  = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LO_RELOAD;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_SETUP: begin
                if (tmr_zero_i) begin
                    state_n    = ST_HIGH;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HI_RELOAD;
                end
            end
            ST_HIGH: begin
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LO_RELOAD;
                    if (last_bit_i) begin
                        state_n = ST_GAP;
                    end else begin
                        state_n   = ST_SETUP;
                        advance_o = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero_i) begin
                    state_n    = ST_LOAD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LD_RELOAD;
                end
            end
            ST_LOAD: begin
                if (tmr_zero_i) begin
                    state_n = ST_FIN;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Registered pin decode from the next state (glitch-free outputs)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            load_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            sclk_q <= (state_n == ST_HIGH);
            load_q <= (state_n == ST_LOAD);
            busy_q <= (state_n != ST_IDLE) && (state_n != ST_FIN);
            done_q <= (state_n == ST_FIN);
        end
    end

    assign sclk_o = sclk_q;
    assign load_o = load_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // Pulse-width monitors for the assertions
    logic [RUN_W-1:0] hi_run, lo_run, ld_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
            ld_run <= '0;
        end else begin
            hi_run <= sclk_q ? ((hi_run == '1) ? hi_run : hi_run + 1'b1) : '0;
            ld_run <= load_q ? ((ld_run == '1) ? ld_run : ld_run + 1'b1) : '0;
            lo_run <= (busy_q && !sclk_q) ? ((lo_run == '1) ? lo_run : lo_run + 1'b1) : '0;
        end
    end

    AST_SCLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk_q) |-> (hi_run >= RUN_W'(HI_CYC))); // R6
    AST_SCLK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk_q) |-> (lo_run >= RUN_W'(LO_CYC))); // R6
    AST_LOAD_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(load_q) |-> (ld_run >= RUN_W'(LD_CYC))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R8
    AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> $fell(load_q)); // R8

endmodule

// File: rtl/vfd_chain_loader.sv
module vfd_chain_loader
    import vfd_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int DRV_BITS      = 20
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic                                  dual_i,
    input  logic [((2*DRV_BITS+7)/8)*8-1:0]       frame_i,
    output logic                                  vfd_din_o,
    output logic                                  vfd_clk_o,
    output logic                                  vfd_load_o,
    output logic                                  busy_o,
    output logic                                  done_o
);

    localparam int FRAME_W  = 2 * DRV_BITS;
    localparam int IN_W     = ((FRAME_W + 7) / 8) * 8;
    localparam int HI_CYC   = at_least_one(div_up(SCLK_HIGH_MIN_PS, CLK_PERIOD_PS));
    localparam int LO_CYC   = at_least_one(div_up(SCLK_PERIOD_MIN_PS, CLK_PERIOD_PS) - HI_CYC);
    localparam int LD_CYC   = at_least_one(div_up(LOAD_HIGH_MIN_PS, CLK_PERIOD_PS));
    localparam int PH_MAX   = max3(HI_CYC, LO_CYC, LD_CYC);
    localparam int CNT_W    = $clog2(PH_MAX + 1);

    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             capture, advance, last_bit;

    vfd_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    vfd_frame_shifter #(
        .DRV_BITS (DRV_BITS),
        .FRAME_W  (FRAME_W),
        .IN_W     (IN_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .advance_i (advance),
        .dual_i    (dual_i),
        .frame_i   (frame_i),
        .data_o    (vfd_din_o),
        .last_o    (last_bit)
    );

    vfd_seq_fsm #(
        .CNT_W  (CNT_W),
        .HI_CYC (HI_CYC),
        .LO_CYC (LO_CYC),
        .LD_CYC (LD_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tmr_zero_i (tmr_zero),
        .last_bit_i (last_bit),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .capture_o  (capture),
        .advance_o  (advance),
        .sclk_o     (vfd_clk_o),
        .load_o     (vfd_load_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    AST_DIN_STABLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) vfd_clk_o |-> $stable(vfd_din_o)); // R5
    AST_LOAD_SCLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(vfd_load_o && vfd_clk_o)); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o); // R8
    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (!vfd_clk_o && !vfd_load_o)); // R9

endmodule

// File: tb/vfd_chain_loader_tb.sv
module vfd_chain_loader_tb;

    localparam int TCLK_PS = 4000;
    localparam int HI = (90000 + TCLK_PS - 1) / TCLK_PS;
    localparam int LO = ((200000 + TCLK_PS - 1) / TCLK_PS - HI) < 1 ? 1 : ((200000 + TCLK_PS - 1) / TCLK_PS - HI);
    localparam int LD = (55000 + TCLK_PS - 1) / TCLK_PS;
    localparam int P  = HI + LO;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dual = 1'b0;
    logic [39:0] frame = '0;
    logic        din, sclk, load, busy, done;

    always #2 clk = ~clk;

    vfd_chain_loader #(
        .CLK_PERIOD_PS (TCLK_PS),
        .DRV_BITS      (20)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dual_i     (dual),
        .frame_i    (frame),
        .vfd_din_o  (din),
        .vfd_clk_o  (sclk),
        .vfd_load_o (load),
        .busy_o     (busy),
        .done_o     (done)
    );

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // Reference model: time since the accepting edge
    bit          m_act = 0;
    int          m_t   = 0;
    int          m_n   = 0;
    bit          m_dual = 0;
    logic [39:0] m_frame = '0;
    logic        m_last = 1'b0;

    function automatic int t_end(input int n);
        return n * P + LO + LD;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_act  = 0;
            m_t    = 0;
        end else if (m_act && m_t < t_end(m_n)) begin
            m_t++;
        end else if (start) begin
            // R2/R10: accepted only when not busy (idle or done cycle)
            m_act   = 1;
            m_t     = 0;
            m_dual  = dual;
            m_n     = dual ? 40 : 20;
            m_frame = frame;
        end else begin
            m_act = 0;
        end
    end

    always @(negedge clk) begin
        logic e_din, e_sclk, e_load, e_busy, e_done;
        string tag;
        if (!rst_n) begin
            m_last = 1'b0;
            e_din = 0; e_sclk = 0; e_load = 0; e_busy = 0; e_done = 0;
        end else begin
            e_sclk = m_act && (m_t < m_n * P) && ((m_t % P) >= LO);
            e_load = m_act && (m_t >= m_n * P + LO) && (m_t < t_end(m_n));
            e_done = m_act && (m_t == t_end(m_n));
            e_busy = m_act && (m_t < t_end(m_n));
            if (m_act && m_t < m_n * P) begin
                // R3: single sends frame[19..0]; R4: dual sends frame[39..0]
                m_last = m_frame[m_n - 1 - m_t / P];
            end
            e_din = m_last;
        end
        vectors++;
        if (!rst_n) tag = "R1";
        else if (!e_busy) tag = "R9";
        else tag = m_dual ? "R4" : "R3";
        if (din !== e_din) begin
            fails++;
            $display("FAIL %s/R5 din t=%0d actual=%b expected=%b", tag, m_t, din, e_din);
        end
        if (sclk !== e_sclk) begin
            fails++;
            $display("FAIL %s/R6 sclk t=%0d actual=%b expected=%b", tag, m_t, sclk, e_sclk);
        end
        if (load !== e_load) begin
            fails++;
            $display("FAIL %s/R7 load t=%0d actual=%b expected=%b", tag, m_t, load, e_load);
        end
        if (busy !== e_busy) begin
            fails++;
            $display("FAIL %s/R2 busy t=%0d actual=%b expected=%b", tag, m_t, busy, e_busy);
        end
        if (done !== e_done) begin
            fails++;
            $display("FAIL %s/R8 done t=%0d actual=%b expected=%b", tag, m_t, done, e_done);
        end
    end

    task automatic wait_done();
        while (done !== 1'b1 && cycles < 150000) @(negedge clk);
    endtask

    task automatic send(input bit d, input logic [39:0] f);
        @(negedge clk);
        dual  = d;
        frame = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: single chain, upper nibble of byte 2 and bytes 4..3 set but never sent
        send(1'b0, 40'hFF_FF_F5_3C_96);
        // R4: dual chain
        send(1'b1, 40'hC3_5A_0F_E1_69);
        send(1'b1, 40'hFF_FF_FF_FF_FF);
        // R9: data idles at last bit; now send zeros
        send(1'b1, 40'h00_00_00_00_00);
        send(1'b0, 40'h00_00_0A_AA_AB);

        // R2: start and inputs changed while busy are ignored
        @(negedge clk);
        dual = 1'b0; frame = 40'h00_00_06_5A_C1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        dual = 1'b1; frame = 40'hAA_BB_CC_DD_EE; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);

        // R10: start held through done starts the next frame back to back
        @(negedge clk);
        dual = 1'b0; frame = 40'h00_00_0F_0F_0F; start = 1'b1;
        wait_done();
        dual = 1'b1; frame = 40'h81_42_24_18_E7;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);

        if (cycles >= 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog hang actual=%0d expected<190000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule